// File: doc/BRIEF.md
# Slew Rate Calibration Sequencer

This block runs the whole calibration of a high-speed transmitter's edge-rate setting in hardware, so no software has to step through the sequence. A single start pulse powers a ring oscillator, waits for it to settle, turns on a free-running clock, presents a 1024-cycle measurement window to an external frequency meter and enables that meter. It then polls the meter's valid flag at fixed intervals, up to a timeout, and captures the meter count. The meter and the clocks are shut down in a fixed order, and the captured count is turned into a 3-bit slew-rate code.

The code is the rounded value of `reference_MHz × coefficient × 1024 / count / 1000`. The quotient is formed by a multi-cycle restoring divider, which is used twice: once for the count and once for the rounded scale. A zero count falls back to a default code of 4, and any result above 7 is clamped to 7. The reference frequency and the coefficient are inputs and are captured when a calibration starts. A typical setting is 26 MHz with a coefficient of 17. Timing is derived from a parameter giving the system clock cycles per microsecond. The defaults are a 1 µs settle, a 10 µs poll interval and a 200 µs timeout.

Top module: `srcal_seq`

## Requirements
- R1: After reset, every enable output (oscillator, free-run clock, meter) is low, the window output is 0, busy and done are low, and the code output is 4.
- R2: A start pulse accepted while idle raises the oscillator enable in the next cycle. The free-run clock enable rises after exactly SETTLE_US×CLK_PER_US cycles with only the oscillator enabled.
- R3: The window output equals 1024 from the cycle after the free-run clock rises until the meter enable falls. The meter enable rises one cycle after the window appears and is only ever high while the free-run clock is high.
- R4: The valid flag is sampled in the last cycle of each POLL_US×CLK_PER_US-cycle interval of meter enable. The meter enable stays high for exactly k intervals, where k is the first interval whose sample sees valid high.
- R5: If valid is not seen in TIMEOUT_US/POLL_US samples, the sequence continues anyway, using the count present at the last sample.
- R6: Teardown follows this order. The meter enable falls first. The free-run clock enable falls one cycle later. The new code appears while the oscillator is still enabled. The oscillator enable falls in the cycle after the code is written.
- R7: For a non-zero count C, the code is floor((floor(ref×coef×1024 / C) + 500) / 1000).
- R8: A computed code greater than 7 is written as 7.
- R9: A count of zero writes code 4, and no division is performed.
- R10: The done output is a single-cycle pulse in the first cycle with the oscillator disabled. Busy is high from the cycle after start until that cycle, inclusive, and is low in the cycle after it.
- R11: A start pulse while busy is high (including the done cycle) is ignored: the running sequence keeps its timing, and no new sequence begins afterwards.
- R12: The reference and coefficient inputs are captured when start is accepted; later changes do not affect that calibration's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one calibration |
| ref_mhz_i | input | REF_W (8) | Reference clock frequency in MHz |
| coef_i | input | COEF_W (8) | Calibration coefficient |
| fm_valid_i | input | 1 | Frequency meter result valid |
| fm_count_i | input | CNT_W (24) | Frequency meter count |
| osc_en_o | output | 1 | Ring oscillator enable |
| frck_en_o | output | 1 | Free-running clock enable |
| fm_en_o | output | 1 | Frequency meter enable |
| fm_window_o | output | WIN_W (11) | Measurement window length, 0 when not presented |
| sr_code_o | output | 3 | Slew-rate code |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The sequence is exercised with the valid flag arriving in the very first sample cycle, on the last cycle of an interval, in a later interval, and never. These cases separate an off-by-one in the interval sampling from a wrong timeout count. The count values are chosen to land on codes 0, 2, 3 and 5 from the formula, to exceed 7 through a small count and through a count of 1, and to hit the zero fallback. Consecutive runs therefore write different codes, which exposes a write placed after the oscillator shutdown. One run changes the reference mid-sequence and fires extra start pulses during the settle phase and in the done cycle. That run shows whether the operands were captured at start and whether a busy start is truly dropped.

// File: rtl/srcal_pkg.sv
package srcal_pkg;

  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_FALLBACK = 3'd4;
  localparam logic [CODE_W-1:0] CODE_CEIL     = 3'd7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CLKON,
    ST_WINSET,
    ST_MEASURE,
    ST_METEROFF,
    ST_CLKOFF,
    ST_DIVQ,
    ST_DIVR,
    ST_WRITE,
    ST_DONE
  } cal_state_e;

endpackage

// File: rtl/srcal_tick_timer.sv
module srcal_tick_timer #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] last_i,
  output logic         last_o
);

  logic [W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || last_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R4: the interval counter never passes its terminal value
  assert_tick_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= last_i));

endmodule

// File: rtl/srcal_divider.sv
module srcal_divider #(
  parameter int W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);

  localparam int LW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dvs_q;
  logic [W-1:0]  dvd_q;
  logic [LW-1:0] left_q;
  logic          run_q;
  logic          done_q;

  logic [W:0]    rem_sh;
  logic          fits;

  assign rem_sh = {rem_q[W-1:0], quo_q[W-1]};
  assign fits   = (rem_sh >= {1'b0, dvs_q});
  assign done_o = done_q;
  assign quot_o = quo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      quo_q  <= dividend_i;
      dvs_q  <= divisor_i;
      dvd_q  <= dividend_i;
      left_q <= LW'(W);
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (run_q) begin
        rem_q  <= fits ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
        quo_q  <= {quo_q[W-2:0], fits};
        left_q <= left_q - 1'b1;
        if (left_q == LW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // Exactness check on completion: quotient * divisor + remainder == dividend
  logic [2*W-1:0] recon;
  assign recon = ({{W{1'b0}}, quo_q} * {{W{1'b0}}, dvs_q}) + {{(W-1){1'b0}}, rem_q};

  // R7: each division result is exact with a remainder below the divisor
  assert_div_exact_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (recon == {{W{1'b0}}, dvd_q}) && (rem_q < {1'b0, dvs_q}));

  // R9: a zero divisor is never launched
  assert_div_nonzero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (divisor_i != '0));

endmodule

// File: rtl/srcal_ctrl.sv
module srcal_ctrl
  import srcal_pkg::*;
#(
  parameter int CLK_PER_US = 4,
  parameter int SETTLE_US  = 1,
  parameter int POLL_US    = 10,
  parameter int TIMEOUT_US = 200,
  parameter int WINDOW     = 1024,
  parameter int SCALE      = 1000,
  parameter int REF_W      = 8,
  parameter int COEF_W     = 8,
  parameter int CNT_W      = 24,
  parameter int WIN_W      = 11,
  parameter int DIV_W      = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REF_W-1:0]  ref_mhz_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              fm_valid_i,
  input  logic [CNT_W-1:0]  fm_count_i,
  output logic              osc_en_o,
  output logic              frck_en_o,
  output logic              fm_en_o,
  output logic [WIN_W-1:0]  fm_window_o,
  output logic [CODE_W-1:0] sr_code_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              div_start_o,
  output logic [DIV_W-1:0]  div_dividend_o,
  output logic [DIV_W-1:0]  div_divisor_o,
  input  logic              div_done_i,
  input  logic [DIV_W-1:0]  div_quot_i
);

  localparam int SETTLE_CYC = SETTLE_US * CLK_PER_US;
  localparam int POLL_CYC   = POLL_US * CLK_PER_US;
  localparam int NPOLL      = TIMEOUT_US / POLL_US;
  localparam int TMAX       = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int TW         = $clog2(TMAX + 1);
  localparam int NP_W       = $clog2(NPOLL + 1);
  localparam int HALF       = SCALE / 2;

  // Arithmetic kept in functions so the formula is readable in one place
  function automatic logic [DIV_W-1:0] cal_numerator(input logic [REF_W-1:0] r,
                                                     input logic [COEF_W-1:0] c);
    return DIV_W'(r) * DIV_W'(c) * DIV_W'(WINDOW);
  endfunction

  function automatic logic [CODE_W-1:0] cal_clamp(input logic [DIV_W-1:0] q);
    return (q > DIV_W'(CODE_CEIL)) ? CODE_CEIL : q[CODE_W-1:0];
  endfunction

  cal_state_e        state_q;
  logic [NP_W-1:0]   npoll_q;
  logic [CNT_W-1:0]  count_q;
  logic [REF_W-1:0]  ref_q;
  logic [COEF_W-1:0] coef_q;
  logic [CODE_W-1:0] code_q;

  // Named internal events
  logic              tmr_run;
  logic [TW-1:0]     tmr_last;
  logic              tick;
  logic              poll_hit;
  logic              poll_giveup;
  logic              zero_count;

  assign tmr_run     = (state_q == ST_SETTLE) || (state_q == ST_MEASURE);
  assign tmr_last    = (state_q == ST_SETTLE) ? TW'(SETTLE_CYC - 1) : TW'(POLL_CYC - 1);
  assign poll_hit    = (state_q == ST_MEASURE) && tick && fm_valid_i;
  assign poll_giveup = (state_q == ST_MEASURE) && tick && !fm_valid_i &&
                       (npoll_q == NP_W'(NPOLL - 1));
  assign zero_count  = (count_q == '0);

  srcal_tick_timer #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tmr_run),
    .last_i (tmr_last),
    .last_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      npoll_q <= '0;
      count_q <= '0;
      ref_q   <= '0;
      coef_q  <= '0;
      code_q  <= CODE_FALLBACK;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ref_q   <= ref_mhz_i;
          coef_q  <= coef_i;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE:  if (tick) state_q <= ST_CLKON;
        ST_CLKON:   state_q <= ST_WINSET;
        ST_WINSET: begin
          npoll_q <= '0;
          state_q <= ST_MEASURE;
        end
        ST_MEASURE: if (tick) begin
          if (poll_hit || poll_giveup) begin
            count_q <= fm_count_i;
            state_q <= ST_METEROFF;
          end else begin
            npoll_q <= npoll_q + 1'b1;
          end
        end
        ST_METEROFF: state_q <= ST_CLKOFF;
        ST_CLKOFF: begin
          if (zero_count) begin
            code_q  <= CODE_FALLBACK;
            state_q <= ST_WRITE;
          end else begin
            state_q <= ST_DIVQ;
          end
        end
        ST_DIVQ: if (div_done_i) state_q <= ST_DIVR;
        ST_DIVR: if (div_done_i) begin
          code_q  <= cal_clamp(div_quot_i);
          state_q <= ST_WRITE;
        end
        ST_WRITE: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign osc_en_o    = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign frck_en_o   = (state_q == ST_CLKON) || (state_q == ST_WINSET) ||
                       (state_q == ST_MEASURE) || (state_q == ST_METEROFF);
  assign fm_window_o = ((state_q == ST_WINSET) || (state_q == ST_MEASURE)) ?
                       WIN_W'(WINDOW) : '0;
  assign fm_en_o     = (state_q == ST_MEASURE);
  assign sr_code_o   = code_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

  assign div_start_o    = ((state_q == ST_CLKOFF) && !zero_count) ||
                          ((state_q == ST_DIVQ) && div_done_i);
  assign div_dividend_o = (state_q == ST_CLKOFF) ? cal_numerator(ref_q, coef_q)
                                                 : (div_quot_i + DIV_W'(HALF));
  assign div_divisor_o  = (state_q == ST_CLKOFF) ? DIV_W'(count_q) : DIV_W'(SCALE);

  // R3: the free-run clock only runs under an enabled oscillator
  assert_frck_inside_osc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frck_en_o |-> osc_en_o);

  // R3: meter enabled only with free-run clock and the window presented
  assert_meter_needs_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fm_en_o |-> (frck_en_o && (fm_window_o == WIN_W'(WINDOW))));

  // R6: the code only changes while the oscillator is still enabled
  assert_code_write_under_osc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_q) |-> osc_en_o);

  // R6: meter enable falls while the free-run clock stays on for that cycle
  assert_meter_before_clock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fm_en_o) |-> frck_en_o);

  // R11: a sequence only begins from the idle state
  assert_start_only_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> $past(!busy_o));

  // R5: never more samples than the timeout allows
  assert_poll_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fm_en_o |-> (npoll_q < NP_W'(NPOLL)));

  // R10: done lasts a single cycle and returns to idle
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

endmodule

// File: rtl/srcal_seq.sv
module srcal_seq
  import srcal_pkg::*;
#(
  parameter int CLK_PER_US = 4,
  parameter int SETTLE_US  = 1,
  parameter int POLL_US    = 10,
  parameter int TIMEOUT_US = 200,
  parameter int WINDOW     = 1024,
  parameter int SCALE      = 1000,
  parameter int REF_W      = 8,
  parameter int COEF_W     = 8,
  parameter int CNT_W      = 24,
  localparam int WIN_W     = $clog2(WINDOW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REF_W-1:0]  ref_mhz_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              fm_valid_i,
  input  logic [CNT_W-1:0]  fm_count_i,
  output logic              osc_en_o,
  output logic              frck_en_o,
  output logic              fm_en_o,
  output logic [WIN_W-1:0]  fm_window_o,
  output logic [2:0]        sr_code_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int NUM_W  = REF_W + COEF_W + WIN_W;
  localparam int SC_W   = $clog2(SCALE + 1);
  localparam int BASE_A = (NUM_W > CNT_W) ? NUM_W : CNT_W;
  localparam int BASE_W = (BASE_A > SC_W) ? BASE_A : SC_W;
  localparam int DIV_W  = BASE_W + 1;

  logic             div_start;
  logic [DIV_W-1:0] div_dividend;
  logic [DIV_W-1:0] div_divisor;
  logic             div_done;
  logic [DIV_W-1:0] div_quot;

  srcal_ctrl #(
    .CLK_PER_US (CLK_PER_US),
    .SETTLE_US  (SETTLE_US),
    .POLL_US    (POLL_US),
    .TIMEOUT_US (TIMEOUT_US),
    .WINDOW     (WINDOW),
    .SCALE      (SCALE),
    .REF_W      (REF_W),
    .COEF_W     (COEF_W),
    .CNT_W      (CNT_W),
    .WIN_W      (WIN_W),
    .DIV_W      (DIV_W)
  ) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .ref_mhz_i      (ref_mhz_i),
    .coef_i         (coef_i),
    .fm_valid_i     (fm_valid_i),
    .fm_count_i     (fm_count_i),
    .osc_en_o       (osc_en_o),
    .frck_en_o      (frck_en_o),
    .fm_en_o        (fm_en_o),
    .fm_window_o    (fm_window_o),
    .sr_code_o      (sr_code_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .div_start_o    (div_start),
    .div_dividend_o (div_dividend),
    .div_divisor_o  (div_divisor),
    .div_done_i     (div_done),
    .div_quot_i     (div_quot)
  );

  srcal_divider #(.W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (div_dividend),
    .divisor_i  (div_divisor),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

endmodule

// File: tb/srcal_seq_bench.sv
module srcal_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int S = 4;     // settle cycles at defaults
  localparam int P = 40;    // poll interval cycles at defaults
  localparam int NPOLL = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  ref_mhz = 8'd26;
  logic [7:0]  coef = 8'd17;
  logic        fm_valid = 1'b0;
  logic [23:0] fm_count = '0;
  logic        osc_en, frck_en, fm_en, busy, done;
  logic [10:0] fm_window;
  logic [2:0]  sr_code;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srcal_seq u_srcal_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ref_mhz_i(ref_mhz), .coef_i(coef),
    .fm_valid_i(fm_valid), .fm_count_i(fm_count), .osc_en_o(osc_en), .frck_en_o(frck_en),
    .fm_en_o(fm_en), .fm_window_o(fm_window), .sr_code_o(sr_code), .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural statement of R7/R8/R9
  function automatic int model_code(input int r, input int c, input int cnt);
    longint q;
    longint v;
    if (cnt == 0) return 4;
    q = (longint'(r) * c * 1024) / cnt;
    v = (q + 500) / 1000;
    return (v > 7) ? 7 : int'(v);
  endfunction

  // vdel < 0: valid never rises
  task automatic run_cal(input int r, input int c, input int cnt, input int vdel,
                         input bit poke, input string req);
    int k;
    int tend;
    int expc;
    int prev;
    bit seen;
    logic [4:0] act, exp;
    k = (vdel < 0) ? NPOLL : ((vdel + P) / P);
    if (k > NPOLL) k = NPOLL;
    tend = S + 3 + k * P;
    expc = model_code(r, c, cnt);
    ref_mhz = 8'(r); coef = 8'(c); fm_count = 24'(cnt); fm_valid = 1'b0;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    for (int t = 0; t <= tend; t++) begin
      if (t > 0) @(negedge clk);
      if (poke && t == 2) start = 1'b1;         // R11: start during settle
      if (poke && t == 3) start = 1'b0;
      if (poke && t == 5) ref_mhz = 8'(r + 7);  // R12: late operand change
      if (vdel >= 0 && t == S + 2 + vdel) fm_valid = 1'b1;
      exp = {1'b1, (t >= S && t <= S + 2 + k * P),
             (t >= S + 2 && t < S + 2 + k * P),
             (t >= S + 1 && t < S + 2 + k * P), 1'b1};
      act = {osc_en, frck_en, fm_en, (fm_window != 0), busy};
      check(act == exp && (fm_window == 0 || fm_window == 11'd1024) && !done,
            $sformatf("R2 R3 R4 R5 R6 R11 trace t=%0d (%s)", t, req), act, exp);
    end
    fm_valid = 1'b0;
    prev = sr_code;
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (!osc_en) begin
        seen = 1;
        check(done && busy, {"R10 done in first osc-off cycle ", req}, {done, busy}, 2'b11);
        check(sr_code == expc, {"R7 R8 R9 R12 code ", req}, sr_code, expc);
        check(prev == expc, {"R6 code written before osc off ", req}, prev, expc);
        if (poke) start = 1'b1;                 // R11: start during done
      end else begin
        prev = sr_code;
      end
    end
    check(seen, {"R6 oscillator shut down ", req}, seen, 1);
    @(negedge clk); start = 1'b0;
    check(!done && !busy && !osc_en, {"R10 back to idle ", req}, {done, busy, osc_en}, 0);
    if (poke) begin
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        check(!osc_en && !busy, "R11 no restart after busy start", {osc_en, busy}, 0);
      end
    end
    ref_mhz = 8'(r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({osc_en, frck_en, fm_en, busy, done} == 0 && fm_window == 0,
          "R1 enables low in reset", {osc_en, frck_en, fm_en, busy, done}, 0);
    check(sr_code == 3'd4, "R1 reset code", sr_code, 4);
    rst_n = 1'b1;
    @(negedge clk);
    check({osc_en, frck_en, fm_en, busy, done} == 0 && sr_code == 3'd4,
          "R1 idle after reset", {osc_en, frck_en, fm_en, busy, done, sr_code}, 4);

    run_cal(26, 17, 100,  0,  0, "R7 nominal valid at first sample");
    run_cal(26, 17, 130,  50, 0, "R4 valid in second interval");
    run_cal(26, 17, 1000, -1, 0, "R5 timeout");
    run_cal(26, 17, 50,   10, 0, "R8 clamp");
    run_cal(26, 17, 0,    5,  0, "R9 zero count");
    run_cal(40, 10, 80,   79, 1, "R11 R12 busy start and late ref");
    run_cal(26, 17, 1,    0,  0, "R8 count of one");
    run_cal(26, 17, 200,  39, 0, "R4 valid on last cycle of interval");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule